// File: doc/BRIEF.md
# Variable-Length Byte DMA Channel

This block is one byte-wide DMA channel. Software loads a source address, a destination address, a length byte pair, two address-step modes and a transfer type, then pulses `arm` to latch them. Every `trig` pulse then starts work on a simple memory port. Each byte moves as a read cycle followed by a write cycle, and the write data is the value returned by the read.

The count can be fixed, taken straight from the programmed length. It can also be variable, taken from the value of the first byte moved plus an offset that depends on the mode, and never larger than the programmed length. The transfer type sets two things: whether one trigger moves one byte or the whole block, and whether the channel reloads and stays armed after it finishes.

Top module: `vl_dma_channel`

## Requirements
- R1: After reset `mem_re`, `mem_we` and `done` are low, and the channel is idle and disarmed.
- R2: Length modes 0 and 7, and the spare codes 5 and 6, move exactly the programmed length in bytes.
- R3: A byte is a read cycle (`mem_re`, address = source pointer) followed at once by a write cycle (`mem_we`, address = destination pointer, `mem_wdata` = the read data returned one cycle after `mem_re`). `done` is high for the one cycle after the final write.
- R4: In the variable modes the total byte count, including the first byte, is the first byte's value plus an offset. The offset is +1 for mode 1, +0 for mode 2, +2 for mode 3 and +3 for mode 4. The first byte is also written to the destination.
- R5: A variable count larger than the programmed length is cut to that length. A derived count of zero still moves the first byte only.
- R6: Each pointer steps after every byte under its own 2-bit code: 0 holds, 1 adds one, 2 adds two, 3 subtracts one. The 16-bit addresses wrap.
- R7: Transfer type 0 moves one byte per trigger. `done` follows the trigger that moves the last byte.
- R8: Transfer type 1 moves the whole count back-to-back on one trigger.
- R9: Types 2 and 3 act as types 0 and 1. On completion they reload the start addresses and the count and stay armed, so the next trigger starts over.
- R10: Types 0 and 1 disarm on completion. A later trigger causes no memory access and no `done` until the channel is armed again.
- R11: A programmed length of zero raises `done` in the cycle after the trigger, with no memory access.
- R12: A trigger that arrives while a transfer is running is ignored.
- R13: The length mode is `cfg_len_hi[7:5]`. The length is `{cfg_len_hi[4:0], cfg_len_lo}`, so counts above 255 are possible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Latch configuration and arm (accepted while idle) |
| trig | input | 1 | Start request |
| cfg_src | input | 16 | Start source address |
| cfg_dst | input | 16 | Start destination address |
| cfg_src_step | input | 2 | Source step code |
| cfg_dst_step | input | 2 | Destination step code |
| cfg_type | input | 2 | Bit 0: whole block per trigger; bit 1: reload and stay armed |
| cfg_len_hi | input | 8 | Length mode [7:5], upper length bits [4:0] |
| cfg_len_lo | input | 8 | Lower length byte |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |
| busy | output | 1 | A transfer is in progress |
| armed | output | 1 | The channel accepts triggers |
| done | output | 1 | One-cycle completion pulse |

## Verification
A trigger sampled at a clock edge puts the read strobe in the next cycle and the write strobe one cycle after that. Each further byte of a block adds two cycles. The done pulse falls in the cycle after the final write, or in the cycle right after the trigger when the length is zero. For every trigger, the bench's behavioural model lays out this exact cycle schedule in a queue, including the first-byte count arithmetic. The bench compares the strobes, address, data and done on every falling edge, and expects a fully quiet bus whenever the queue is empty. A wrong count, a late or early strobe, or a missed trigger that should have been ignored shows up in the cycle where it happens.

// File: rtl/vld_pkg.sv
package vld_pkg;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} state_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_INC2 = 2'd2,
    STEP_DEC  = 2'd3
  } step_e;

  // Length modes 1..4 derive the count from the first byte.
  function automatic logic mode_is_var(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction

  function automatic logic [1:0] mode_offset(input logic [2:0] m);
    case (m)
      3'd1:    return 2'd1;
      3'd3:    return 2'd2;
      3'd4:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/vld_addr_gen.sv
module vld_addr_gen import vld_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          restore,
  input  logic          adv,
  input  logic [AW-1:0] cfg_base,
  input  logic [1:0]    cfg_step,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] base_q, ptr_q;
  step_e         step_q;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input step_e s);
    case (s)
      STEP_INC:  return a + AW'(1);
      STEP_INC2: return a + AW'(2);
      STEP_DEC:  return a - AW'(1);
      default:   return a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
      step_q <= STEP_HOLD;
    end else if (capture) begin
      base_q <= cfg_base;
      ptr_q  <= cfg_base;
      step_q <= step_e'(cfg_step);
    end else if (restore) begin
      ptr_q <= base_q;
    end else if (adv) begin
      ptr_q <= next_addr(ptr_q, step_q);
    end
  end

  assign ptr = ptr_q;

  // R6: hold code keeps the pointer, decrement code lowers it by one
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !capture && !restore && step_q == STEP_HOLD) |=> ptr_q == $past(ptr_q));
  a_r6_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !capture && !restore && step_q == STEP_DEC) |=> ptr_q == $past(ptr_q) - AW'(1));
  // R9: a reload returns the pointer to the latched start
  a_r9_reload_base: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && !capture) |=> ptr_q == $past(base_q));

endmodule

// File: rtl/vld_count_unit.sv
module vld_count_unit import vld_pkg::*; #(
  parameter int LW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          restore,
  input  logic          unit_done,
  input  logic [LW-1:0] cfg_len,
  input  logic [2:0]    cfg_mode,
  input  logic [7:0]    first_data,
  output logic          last_unit,
  output logic          len_zero
);

  localparam int SW = LW + 1;

  logic [LW-1:0] len_q, remain_q, derived, next_remain;
  logic [2:0]    mode_q;
  logic          first_pend, use_derived;

  // first value plus offset, cut to the limit, never below one
  function automatic logic [LW-1:0] clamp_count(input logic [7:0] first,
                                                input logic [1:0] off,
                                                input logic [LW-1:0] lim);
    logic [SW-1:0] s;
    s = SW'(first) + SW'(off);
    if (s > SW'(lim)) s = SW'(lim);
    if (s == '0) s = SW'(1);
    return s[LW-1:0];
  endfunction

  assign derived     = clamp_count(first_data, mode_offset(mode_q), len_q);
  assign use_derived = first_pend && mode_is_var(mode_q);
  assign next_remain = use_derived ? derived - LW'(1) : remain_q - LW'(1);
  assign last_unit   = (next_remain == '0);
  assign len_zero    = (len_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q      <= '0;
      mode_q     <= '0;
      remain_q   <= '0;
      first_pend <= 1'b0;
    end else if (capture) begin
      len_q      <= cfg_len;
      mode_q     <= cfg_mode;
      remain_q   <= cfg_len;
      first_pend <= 1'b1;
    end else if (restore) begin
      remain_q   <= len_q;
      first_pend <= 1'b1;
    end else if (unit_done) begin
      remain_q   <= next_remain;
      first_pend <= 1'b0;
    end
  end

  // R5: the count left never exceeds the programmed length
  a_r5_remain_bound: assert property (@(posedge clk) disable iff (!rst_n)
    remain_q <= len_q);
  // R11: a zero length never reaches a byte move
  a_r11_no_unit_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |-> !len_zero);

endmodule

// File: rtl/vl_dma_channel.sv
module vl_dma_channel import vld_pkg::*; #(
  parameter int AW          = 16,
  parameter int LEN_HI_BITS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          trig,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [1:0]    cfg_src_step,
  input  logic [1:0]    cfg_dst_step,
  input  logic [1:0]    cfg_type,
  input  logic [7:0]    cfg_len_hi,
  input  logic [7:0]    cfg_len_lo,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          armed,
  output logic          done
);

  localparam int LW = LEN_HI_BITS + 8;

  state_e        state_q;
  logic [1:0]    type_q;
  logic          armed_q, done_q;
  logic [AW-1:0] src_ptr, dst_ptr;
  logic [LW-1:0] cfg_len;
  logic          last_unit, len_zero;

  // named events
  logic arm_ev, trig_ev, zero_ev, start_ev, wr_ev, finish_ev, restore_ev;

  assign cfg_len    = {cfg_len_hi[LEN_HI_BITS-1:0], cfg_len_lo};
  assign arm_ev     = arm && (state_q == ST_IDLE);
  assign trig_ev    = trig && armed_q && (state_q == ST_IDLE) && !arm;
  assign zero_ev    = trig_ev && len_zero;
  assign start_ev   = trig_ev && !len_zero;
  assign wr_ev      = (state_q == ST_WR);
  assign finish_ev  = zero_ev || (wr_ev && last_unit);
  assign restore_ev = finish_ev && type_q[1];

  vld_addr_gen #(.AW(AW)) i_src_gen (
    .clk(clk), .rst_n(rst_n), .capture(arm_ev), .restore(restore_ev), .adv(wr_ev),
    .cfg_base(cfg_src), .cfg_step(cfg_src_step), .ptr(src_ptr));

  vld_addr_gen #(.AW(AW)) i_dst_gen (
    .clk(clk), .rst_n(rst_n), .capture(arm_ev), .restore(restore_ev), .adv(wr_ev),
    .cfg_base(cfg_dst), .cfg_step(cfg_dst_step), .ptr(dst_ptr));

  vld_count_unit #(.LW(LW)) i_count (
    .clk(clk), .rst_n(rst_n), .capture(arm_ev), .restore(restore_ev), .unit_done(wr_ev),
    .cfg_len(cfg_len), .cfg_mode(cfg_len_hi[7:5]), .first_data(mem_rdata),
    .last_unit(last_unit), .len_zero(len_zero));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      type_q  <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish_ev;
      if (arm_ev) begin
        type_q  <= cfg_type;
        armed_q <= 1'b1;
      end else if (finish_ev && !type_q[1]) begin
        armed_q <= 1'b0;
      end
      case (state_q)
        ST_IDLE: if (start_ev) state_q <= ST_RD;
        ST_RD:   state_q <= ST_WR;
        ST_WR:   state_q <= (!last_unit && type_q[0]) ? ST_RD : ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_re    = (state_q == ST_RD);
  assign mem_we    = wr_ev;
  assign mem_addr  = mem_re ? src_ptr : (mem_we ? dst_ptr : '0);
  assign mem_wdata = mem_we ? mem_rdata : '0;
  assign busy      = (state_q != ST_IDLE);
  assign armed     = armed_q;
  assign done      = done_q;

  // R3: read and write never share a cycle, and each read is followed by its write
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> mem_we);
  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re));
  // R11: the done cycle carries no memory access
  a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_re && !mem_we));
  // R10: a one-shot type is disarmed when done shows
  a_r10_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !type_q[1]) |-> !armed);
  // R12: a running transfer is not disturbed by trig
  a_r12_busy_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig) |=> (busy || done));

endmodule

// File: tb/test_vl_dma_channel.sv
`timescale 1ns/1ps
module test_vl_dma_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0, trig = 1'b0;
  logic [15:0] cfg_src = '0, cfg_dst = '0;
  logic [1:0]  cfg_src_step = '0, cfg_dst_step = '0, cfg_type = '0;
  logic [7:0]  cfg_len_hi = '0, cfg_len_lo = '0;
  logic        mem_re, mem_we, busy, armed, done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  rdata = '0;

  always #2 clk = ~clk;  // 250 MHz

  vl_dma_channel i_vl_dma_channel (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_src_step(cfg_src_step),
    .cfg_dst_step(cfg_dst_step), .cfg_type(cfg_type), .cfg_len_hi(cfg_len_hi),
    .cfg_len_lo(cfg_len_lo), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(rdata), .busy(busy), .armed(armed), .done(done));

  // bench memory, 256 bytes, indexed by the low address byte
  logic [7:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_re) rdata <= mem[mem_addr[7:0]];
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  typedef struct {
    bit re; bit we; bit dn;
    logic [15:0] a; logic [7:0] d;
    string tag;
  } exp_t;
  exp_t  q[$];
  string idle_tag = "R1";
  int    total = 0, bad = 0;
  bit    finished = 0;

  // per-cycle comparison; an empty queue means a quiet bus (R1, R10, R12)
  always @(negedge clk) begin
    exp_t e;
    bit ok;
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.re = 0; e.we = 0; e.dn = 0; e.a = '0; e.d = '0; e.tag = idle_tag;
    end
    ok = (mem_re === e.re) && (mem_we === e.we) && (done === e.dn);
    if (ok && (e.re || e.we) && mem_addr !== e.a) ok = 0;
    if (ok && e.we && mem_wdata !== e.d) ok = 0;
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: re/we/done/addr/data got %b%b%b %h %h exp %b%b%b %h %h",
               e.tag, mem_re, mem_we, done, mem_addr, mem_wdata,
               e.re, e.we, e.dn, e.a, e.d);
    end
  end

  // behavioural model state
  logic [15:0] m_src, m_dst, m_src0, m_dst0;
  int m_sstep, m_dstep, m_type, m_mode, m_len, m_left;
  bit m_first, m_armed;
  int add_for_mode [int] = '{1: 1, 2: 0, 3: 2, 4: 3};  // R4 offsets

  function automatic int step_amount(int code);
    case (code)
      1: return 1;
      2: return 2;
      3: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic void push(bit re, bit we, bit dn, logic [15:0] a, logic [7:0] d, string tag);
    exp_t e;
    e.re = re; e.we = we; e.dn = dn; e.a = a; e.d = d; e.tag = tag;
    q.push_back(e);
  endfunction

  task automatic do_arm(input logic [15:0] s, input logic [15:0] d, input int ss, input int ds,
                        input int typ, input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk); #1;
    cfg_src = s; cfg_dst = d; cfg_src_step = 2'(ss); cfg_dst_step = 2'(ds);
    cfg_type = 2'(typ); cfg_len_hi = hi; cfg_len_lo = lo; arm = 1'b1;
    // R13: mode in the top three bits, length = five low bits then the low byte
    m_mode = int'(hi[7:5]);
    m_len  = int'(hi[4:0]) * 256 + int'(lo);
    m_src = s; m_dst = d; m_src0 = s; m_dst0 = d;
    m_sstep = ss; m_dstep = ds; m_type = typ;
    m_left = m_len; m_first = 1; m_armed = 1;
    @(negedge clk); #1;
    arm = 1'b0;
  endtask

  task automatic model_trigger(input string tag);
    int unit_cnt;
    logic [7:0] v;
    if (!m_armed) return;
    if (m_len == 0) begin  // R11
      push(0, 0, 1, '0, '0, tag);
      if ((m_type & 2) == 0) m_armed = 0;
      return;
    end
    forever begin
      v = mem[m_src[7:0]];
      push(1, 0, 0, m_src, '0, tag);
      push(0, 1, 0, m_dst, v, tag);
      if (m_first && add_for_mode.exists(m_mode)) begin
        unit_cnt = int'(v) + add_for_mode[m_mode];
        if (unit_cnt > m_len) unit_cnt = m_len;   // R5
        if (unit_cnt < 1) unit_cnt = 1;
        m_left = unit_cnt;
      end
      m_first = 0;
      m_left  = m_left - 1;
      m_src   = m_src + 16'(step_amount(m_sstep));
      m_dst   = m_dst + 16'(step_amount(m_dstep));
      if (m_left == 0) begin
        push(0, 0, 1, '0, '0, tag);
        if ((m_type & 2) != 0) begin  // R9
          m_src = m_src0; m_dst = m_dst0; m_left = m_len; m_first = 1;
        end else m_armed = 0;          // R10
        break;
      end
      if ((m_type & 1) == 0) break;    // R7
    end
  endtask

  task automatic pulse_trig(input string tag);
    @(negedge clk); #1;
    trig = 1'b1;
    model_trigger(tag);
    @(negedge clk); #1;
    trig = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, got no end exp end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    mem[8'h40] = 8'd3;  mem[8'h48] = 8'd3;  mem[8'h50] = 8'd3;  mem[8'h58] = 8'd3;
    mem[8'h60] = 8'd20; mem[8'h68] = 8'd0;  mem[8'h10] = 8'hFE;

    repeat (3) @(negedge clk);  // R1: reset-state cycles checked as idle
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_tag = "R10";

    // R8 and R3: block of four, both pointers increment
    do_arm(16'h0020, 16'h0080, 1, 1, 1, 8'h00, 8'd4);
    pulse_trig("R3/R8"); drain();
    pulse_trig("R10"); drain();            // disarmed: quiet bus expected
    // R6: source decrement, destination +2, mode 7
    do_arm(16'h0030, 16'h0090, 3, 2, 1, 8'hE0, 8'd3);
    pulse_trig("R6"); drain();
    // R2: spare mode 5 behaves as fixed length, source held
    do_arm(16'h0020, 16'h00A0, 0, 1, 1, 8'hA0, 8'd2);
    pulse_trig("R2"); drain();
    // R4: each variable mode with first byte 3
    do_arm(16'h0040, 16'h0080, 1, 1, 1, 8'h20, 8'd10); pulse_trig("R4"); drain();
    do_arm(16'h0048, 16'h0080, 1, 1, 1, 8'h40, 8'd10); pulse_trig("R4"); drain();
    do_arm(16'h0050, 16'h0080, 1, 1, 1, 8'h60, 8'd10); pulse_trig("R4"); drain();
    do_arm(16'h0058, 16'h0080, 1, 1, 1, 8'h80, 8'd10); pulse_trig("R4"); drain();
    // R5: cut to length, and zero value gives one byte
    do_arm(16'h0060, 16'h0080, 1, 1, 1, 8'h80, 8'd5); pulse_trig("R5"); drain();
    do_arm(16'h0068, 16'h0080, 1, 1, 1, 8'h40, 8'd10); pulse_trig("R5"); drain();
    // R7: one byte per trigger
    do_arm(16'h0020, 16'h00B0, 1, 1, 0, 8'h00, 8'd3);
    for (int k = 0; k < 3; k++) begin pulse_trig("R7"); drain(); end
    pulse_trig("R10"); drain();
    // R9: repeated block, then repeated single
    do_arm(16'h0024, 16'h00C0, 1, 1, 3, 8'h00, 8'd2);
    pulse_trig("R9"); drain(); pulse_trig("R9"); drain();
    do_arm(16'h0028, 16'h00C8, 1, 1, 2, 8'h00, 8'd2);
    for (int k = 0; k < 3; k++) begin pulse_trig("R9"); drain(); end
    // R11: zero length, then one-shot disarm
    do_arm(16'h0020, 16'h00D0, 1, 1, 0, 8'h00, 8'd0);
    pulse_trig("R11"); drain();
    pulse_trig("R10"); drain();
    // R12: extra trigger while a block runs
    do_arm(16'h0020, 16'h00D0, 1, 1, 1, 8'h00, 8'd6);
    pulse_trig("R12");
    repeat (3) @(negedge clk);
    #1 trig = 1'b1;
    @(negedge clk); #1 trig = 1'b0;
    drain();
    // R13: upper length bits, fixed and variable (0xFE + 2 = 256 of 259)
    do_arm(16'h0010, 16'h0090, 0, 0, 1, 8'h01, 8'h03); pulse_trig("R13"); drain();
    do_arm(16'h0010, 16'h0090, 0, 0, 1, 8'h61, 8'h03); pulse_trig("R13"); drain();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule